// File: doc/BRIEF.md
# Dual-Mode DRAM Bank Decoder

This block sits between the upper CPU address lines and the DRAM control logic of a memory subsystem. For each bus cycle it decides whether onboard DRAM claims the address. It also picks which of four RAS/CAS bank groups the downstream 3-to-8 decoders should strobe, gates the memory data buffer, and produces the ninth multiplexed DRAM address bit that larger chips need.

A configuration input selects one of two memory maps, and it may change while the block runs:

- **Small map.** Four banks of 64Kbit parts give 256 KB, one bank per 64 KB region.
- **Large map.** Two banks of 256Kbit parts cover 0–512 KB. Two banks of 64Kbit parts cover 512–576 KB and 576–640 KB, for 640 KB in total.

A refresh acknowledge forces every bank group to receive RAS and keeps the data buffer closed.

All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge. Reset clears every output to 0.

Top module: `dram_bank_decoder`

## Requirements
- R1: While rst_n is low, and on the first check after reset, bank_grp, onboard_hit, data_buf_en, ras_all_grp and ma8 are all 0.
- R2: With mode_640=0, onboard_hit is 1 exactly when addr_hi[3] (A19) and addr_hi[2] (A18) are both 0, i.e. below 256 KB.
- R3: With mode_640=1, onboard_hit is 1 exactly when the address is below 640 KB. That is, A19=0, or A19=1 with A18=0 and A17=0. Addresses at 640 KB and above never hit.
- R4: With mode_640=0, bank_grp equals {A17,A16} (addr_hi[1:0]).
- R5: With mode_640=1, bank_grp is {0,A18} below 512 KB. From 512 KB upward it is {1,A16}: group 2 covers 512–576 KB and group 3 covers 576–640 KB.
- R6: data_buf_en is 1 only when onboard_hit is 1, addr_sel is 1 and refresh_ack is 0.
- R7: With mode_640=1, ma8 equals A16 when row_phase=1 and A17 when row_phase=0.
- R8: With mode_640=0, ma8 is 0 whatever row_phase and the address are.
- R9: When refresh_ack is 1, ras_all_grp is 1 and data_buf_en is 0, whatever the address is.
- R10: Every output changes one clock after its inputs. A mode change takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_hi | input | 4 | CPU address bits A19..A16 (bit 3 = A19) |
| addr_sel | input | 1 | Address-select strobe for the current cycle |
| refresh_ack | input | 1 | DMA refresh acknowledge |
| mode_640 | input | 1 | 1 = 640 KB mixed map, 0 = 256 KB map |
| row_phase | input | 1 | 1 = row address phase, 0 = column phase |
| bank_grp | output | 2 | RAS/CAS bank group select |
| onboard_hit | output | 1 | Address maps to onboard DRAM |
| data_buf_en | output | 1 | Memory data buffer enable |
| ras_all_grp | output | 1 | Strobe RAS on all groups (refresh) |
| ma8 | output | 1 | Ninth multiplexed DRAM address bit |

## Verification
A wrong map decision shows at onboard_hit and data_buf_en one clock after the offending address. A wrong group choice shows at bank_grp on that same clock. Because every output is registered once, a fault cannot hide for more than one cycle. The reference model therefore compares all five outputs on every clock across all address, mode, phase, strobe and refresh combinations, including mode switches between consecutive cycles.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  localparam int ADDR_W = 4;
  localparam int GRP_W  = 2;

  // top-of-map test: is the 64 KB region index inside onboard memory
  function automatic logic map_hit(input logic [ADDR_W-1:0] a, input logic big);
    if (big) return !a[3] || (!a[2] && !a[1]);
    else     return !a[3] && !a[2];
  endfunction

  function automatic logic [GRP_W-1:0] map_grp(input logic [ADDR_W-1:0] a, input logic big);
    if (!big)     return a[1:0];
    else if (!a[3]) return {1'b0, a[2]};
    else          return {1'b1, a[0]};
  endfunction

  function automatic logic extra_bit(input logic [ADDR_W-1:0] a, input logic big, input logic row);
    if (!big) return 1'b0;
    return row ? a[0] : a[1];
  endfunction
endpackage

// File: rtl/ddec_map.sv
module ddec_map
  import dram_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              big,
  output logic              hit,
  output logic [GRP_W-1:0]  grp
);
  always_comb begin
    hit = map_hit(addr, big);
    grp = map_grp(addr, big);
  end
endmodule

// File: rtl/ddec_ma8.sv
module ddec_ma8
  import dram_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              big,
  input  logic              row,
  output logic              bit_out
);
  always_comb bit_out = extra_bit(addr, big, row);
endmodule

// File: rtl/dram_bank_decoder.sv
module dram_bank_decoder
  import dram_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic              addr_sel,
  input  logic              refresh_ack,
  input  logic              mode_640,
  input  logic              row_phase,
  output logic [GRP_W-1:0]  bank_grp,
  output logic              onboard_hit,
  output logic              data_buf_en,
  output logic              ras_all_grp,
  output logic              ma8
);
  logic             hit_c;
  logic [GRP_W-1:0] grp_c;
  logic             ma8_c;
  logic             buf_c;
  logic             armed;

  ddec_map u_map (.addr(addr_hi), .big(mode_640), .hit(hit_c), .grp(grp_c));
  ddec_ma8 u_ma8 (.addr(addr_hi), .big(mode_640), .row(row_phase), .bit_out(ma8_c));

  always_comb buf_c = hit_c && addr_sel && !refresh_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_grp    <= '0;
      onboard_hit <= 1'b0;
      data_buf_en <= 1'b0;
      ras_all_grp <= 1'b0;
      ma8         <= 1'b0;
      armed       <= 1'b0;
    end else begin
      bank_grp    <= grp_c;
      onboard_hit <= hit_c;
      data_buf_en <= buf_c;
      ras_all_grp <= refresh_ack;
      ma8         <= ma8_c;
      armed       <= 1'b1;
    end
  end

  // R2
  small_map_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(mode_640) && ($past(addr_hi[3]) || $past(addr_hi[2])) |-> !onboard_hit);
  // R3
  large_map_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(mode_640) && $past(addr_hi[3]) && ($past(addr_hi[2]) || $past(addr_hi[1])) |-> !onboard_hit);
  // R5
  upper_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && onboard_hit && $past(mode_640) && $past(addr_hi[3]) |-> bank_grp[1]);
  // R6
  buf_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_buf_en |-> onboard_hit);
  // R8
  ma8_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(mode_640) |-> !ma8);
  // R9
  refresh_blocks_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_all_grp |-> !data_buf_en);
endmodule

// File: tb/test_dram_bank_decoder.sv
module test_dram_bank_decoder;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] addr_hi = 0;
  logic addr_sel = 0, refresh_ack = 0, mode_640 = 0, row_phase = 0;
  logic [1:0] bank_grp;
  logic onboard_hit, data_buf_en, ras_all_grp, ma8;
  int checks = 0, fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dram_bank_decoder i_dram_bank_decoder (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .addr_sel(addr_sel),
    .refresh_ack(refresh_ack), .mode_640(mode_640), .row_phase(row_phase),
    .bank_grp(bank_grp), .onboard_hit(onboard_hit), .data_buf_en(data_buf_en),
    .ras_all_grp(ras_all_grp), .ma8(ma8));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural model: address expressed in KB
  task automatic apply_and_check(input int a, input bit big, input bit sel,
                                 input bit rf, input bit row);
    int kb, e_hit, e_grp, e_buf, e_ma8;
    @(negedge clk);
    addr_hi = a[3:0]; mode_640 = big; addr_sel = sel; refresh_ack = rf; row_phase = row;
    kb = a * 64;
    if (big) begin
      e_hit = (kb < 640);
      e_grp = (kb < 512) ? kb / 256 : 2 + ((kb - 512) / 64) % 2;
      e_ma8 = row ? (a % 2) : ((a / 2) % 2);
    end else begin
      e_hit = (kb < 256);
      e_grp = (kb / 64) % 4;
      e_ma8 = 0;
    end
    e_buf = e_hit && sel && !rf;
    @(negedge clk);
    chk(big ? "R3" : "R2", onboard_hit, e_hit);
    chk(big ? "R5" : "R4", bank_grp, e_grp);
    chk(rf ? "R9/R6" : "R6", data_buf_en, e_buf);
    chk("R9", ras_all_grp, rf);
    chk(big ? "R7" : "R8", ma8, e_ma8);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", bank_grp, 0); chk("R1", onboard_hit, 0); chk("R1", data_buf_en, 0);
    chk("R1", ras_all_grp, 0); chk("R1", ma8, 0);
    rst_n = 1;
    // full sweep; each step also covers R10 one-cycle latency
    for (int m = 0; m < 2; m++)
      for (int rf = 0; rf < 2; rf++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 2; r++)
            for (int a = 0; a < 16; a++)
              apply_and_check(a, m[0], s[0], rf[0], r[0]);
    // R10 mode toggling on consecutive cycles, boundary addresses
    for (int k = 0; k < 8; k++) begin
      apply_and_check(9, k[0], 1, 0, k[1]);   // 576 KB
      apply_and_check(10, ~k[0], 1, 0, k[1]); // 640 KB
      apply_and_check(4, k[0], 1, 0, 1);      // 256 KB
      apply_and_check(7, ~k[0], 1, 0, 0);     // 448 KB
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule